// File: doc/BRIEF.md
# SDRAM Open-Page Command Scheduler

This block is the command-scheduling core of a controller for 32-bit single-data-rate SDRAM built from two chip banks of four internal banks each. It takes one word-burst read or write request at a time from an on-chip requester. For each request it issues the ACTIVATE, READ, WRITE and PRECHARGE commands the memory needs. It keeps one open row for each (chip, internal bank) pair, so up to eight pages stay open at once. A request that hits an open page goes straight to the column command. A request that misses closes only the bank it targets, then opens the new row.

Every column command moves an 8-word burst. On writes, per-byte write enables become data masks for the whole burst. Reads always return full words. A read-beat strobe marks the cycles in which data returns, which depend on the selected CAS latency of two or three. Flow is throttled in two ways. A wait output holds the requester until its column command goes out, and the clock-enable output drops whenever the memory has nothing to do. A periodic refresh request precharges every open bank, clears all page tracking and then issues an auto-refresh.

Top module: `sdram_page_sched`

## Requirements
- R1: The word address `req_addr` is split as chip = bit 23, row = bits 22:10, internal bank = bits 9:8 and column = bits 7:0. `sd_cmd` encodes 0 = NOP, 1 = ACTIVATE, 2 = READ, 3 = WRITE, 4 = PRECHARGE and 5 = REFRESH. `sd_cs_n` is active low with one bit per chip. A command to a single bank pulls exactly one bit low, and PRECHARGE-all and REFRESH pull both bits low.
- R2: A request whose row is already open in its (chip, bank) pair gets its column command with no ACTIVATE and no PRECHARGE in between.
- R3: A request to a bank that has a different row open first gets a PRECHARGE of that bank only (`sd_addr[10]` = 0), then an ACTIVATE of the new row, then the column command.
- R4: A request to a closed bank gets an ACTIVATE (row on `sd_addr`) and then the column command. `req_wait` is low with `req_valid` high only in the cycle before the column command appears, and the request is taken on that edge. The column command is READ when `req_write` = 0 and WRITE when it is 1. Its address carries the request column with the low 3 bits cleared.
- R5: Column commands are at least 8 cycles apart. On a write, `sd_dqm` equals the inverted `req_be` in the WRITE cycle and the 7 cycles after it, and is 0 at all other times.
- R6: `sd_dqm` is 0 during reads. `rd_beat` is high for 8 cycles starting CL cycles after the READ cycle, with CL = 3 when `cfg_cas3` = 1 and CL = 2 otherwise.
- R7: ACTIVATE to a column command in the same bank is at least T_RCD cycles. PRECHARGE to ACTIVATE in the same bank is at least T_RP cycles. The last write beat to any PRECHARGE is at least T_WR cycles. REFRESH to any next command is at least T_RFC cycles.
- R8: `sd_cke` is high in every cycle that carries a command. It is low when there is no request, no pending refresh and no burst or write recovery in flight.
- R9: A refresh falls due every REF_INTERVAL cycles and takes priority over requests. If any row is open, a PRECHARGE-all (`sd_addr[10]` = 1) comes first. REFRESH is issued only when all rows are closed, so the next access to any bank needs an ACTIVATE.
- R10: Open rows are tracked separately for all eight (chip, bank) pairs. Opening a row in one pair leaves the others untouched.
- R11: During reset, `sd_cmd` is NOP, and `sd_cke`, `sd_dqm`, `rd_beat` and `req_wait` are 0 (with no request).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 24 | Word address {chip, row, bank, column} |
| req_be | input | 4 | Byte enables for a write burst |
| req_wait | output | 1 | Request held; low means taken on this edge |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Active-low chip selects |
| sd_cmd | output | 3 | Encoded SDRAM command |
| sd_ba | output | 2 | Internal bank address |
| sd_addr | output | 13 | Row, column or precharge-all flag |
| sd_dqm | output | 4 | Byte masks, active during write beats |
| rd_beat | output | 1 | Read data expected this cycle |

## Verification
The bench keeps its own table of open rows and checks every command against it. This catches a design that re-activates a row on a hit, or that closes every bank on a miss instead of just the one it targets. A run of accesses to the same bank number on both chips checks that the two chips keep separate rows; a shared table would show up as spurious precharges. A long idle gap forces a refresh, and the next access must then re-activate its row, which catches stale valid bits. Both CAS latencies and write recovery before a precharge are covered, so an off-by-one in the read-beat window or the recovery count shows up as a wrong-cycle strobe or an early PRECHARGE.

// File: rtl/sps_pkg.sv
// Shared types for the SDRAM open-page scheduler.
package sps_pkg;
    // Encoded command on the memory command pins (code values are fixed).
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } sdr_cmd_e;
endpackage

// File: rtl/sps_open_rows.sv
// Open-row table: one valid bit and one row number per (chip, bank) pair.
// Assumes set and clear never target an entry in the same cycle.
module sps_open_rows #(
    parameter int NENT  = 8,
    parameter int ROW_W = 13,
    parameter int IDX_W = $clog2(NENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             clr_all,
    output logic             look_vld,
    output logic [ROW_W-1:0] look_row,
    output logic             any_open
);
    logic [NENT-1:0]  vld;
    logic [ROW_W-1:0] row_q [NENT];

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        logic             v;
        logic [ROW_W-1:0] r;
        // Track whether this entry's bank has a row open, and which one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v <= 1'b0;
                r <= '0;
            end else if (clr_all || (clr_en && clr_idx == IDX_W'(e))) begin
                v <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(e)) begin
                v <= 1'b1;
                r <= set_row;
            end
        end
        assign vld[e]   = v;
        assign row_q[e] = r;
    end

    assign look_vld = vld[look_idx];
    assign look_row = row_q[look_idx];
    assign any_open = |vld;

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !set_en) |=> !any_open);
endmodule

// File: rtl/sps_ref_timer.sv
// Refresh interval timer: raises a pending flag every INTERVAL cycles that
// stays up until the scheduler reports the refresh as issued.
module sps_ref_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done,
    output logic ref_pend
);
    localparam int CNT_W = $clog2(INTERVAL);
    logic [CNT_W-1:0] cnt;

    // Count the interval and hold the pending flag until served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            ref_pend <= 1'b0;
        end else if (cnt == CNT_W'(INTERVAL - 1)) begin
            cnt      <= '0;
            ref_pend <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
            if (ref_done) ref_pend <= 1'b0;
        end
    end

    // R9
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && !ref_done) |=> ref_pend);
endmodule

// File: rtl/sps_rd_track.sv
// Read-return tracker: marks the BL cycles in which read data comes back,
// starting CAS-latency cycles after a READ appears on the command pins.
module sps_rd_track #(
    parameter int BL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issued,
    input  logic cas3,
    output logic rd_beat,
    output logic rd_busy
);
    localparam int CNT_W = $clog2(BL);
    logic [2:0]       lead;
    logic [CNT_W-1:0] cnt;
    logic             start;

    assign start   = cas3 ? lead[2] : lead[1];
    assign rd_beat = start || (cnt != '0);
    assign rd_busy = (lead != '0) || (cnt != '0);

    // Delay READ issue by the latency, then count out the burst beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead <= '0;
            cnt  <= '0;
        end else begin
            lead <= {lead[1:0], rd_issued};
            if (start)            cnt <= CNT_W'(BL - 1);
            else if (cnt != '0)   cnt <= cnt - 1'b1;
        end
    end

    // R6
    rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cas3) |-> $past(rd_issued, 2));
endmodule

// File: rtl/sdram_page_sched.sv
// SDRAM open-page command scheduler. Serves one burst request at a time,
// keeps a row open per (chip, bank), precharges only the bank a miss hits,
// and runs refresh by precharging all and clearing the page table.
// Assumes T_RCD, T_RP and T_RFC are at least 2 and BL is a power of two.
module sdram_page_sched
    import sps_pkg::*;
#(
    parameter int CHIP_W       = 1,
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 8,
    parameter int DATA_W       = 32,
    parameter int BL           = 8,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_WR         = 2,
    parameter int T_RFC        = 7,
    parameter int REF_INTERVAL = 780,
    parameter int AP_BIT       = 10
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_cas3,
    input  logic                                 req_valid,
    input  logic                                 req_write,
    input  logic [CHIP_W+ROW_W+BANK_W+COL_W-1:0] req_addr,
    input  logic [DATA_W/8-1:0]                  req_be,
    output logic                                 req_wait,
    output logic                                 sd_cke,
    output logic [(1<<CHIP_W)-1:0]               sd_cs_n,
    output logic [2:0]                           sd_cmd,
    output logic [BANK_W-1:0]                    sd_ba,
    output logic [ROW_W-1:0]                     sd_addr,
    output logic [DATA_W/8-1:0]                  sd_dqm,
    output logic                                 rd_beat
);
    localparam int IDX_W  = CHIP_W + BANK_W;
    localparam int NENT   = 1 << IDX_W;
    localparam int NCHIP  = 1 << CHIP_W;
    localparam int BYTES  = DATA_W / 8;
    localparam int BL_LOG = $clog2(BL);
    localparam int M1     = (BL > T_RFC) ? BL : T_RFC;
    localparam int M2     = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAXG   = (M1 > M2) ? M1 : M2;
    localparam int GAP_W  = $clog2(MAXG + 1);
    localparam int WR_W   = $clog2(BL + T_WR + 1);
    localparam int AGE_W  = $clog2(T_RCD + 1);

    // Request fields
    logic [COL_W-1:0]  r_col;
    logic [BANK_W-1:0] r_bank;
    logic [ROW_W-1:0]  r_row;
    logic [CHIP_W-1:0] r_chip;
    logic [IDX_W-1:0]  r_idx;
    assign r_col  = req_addr[COL_W-1:0];
    assign r_bank = req_addr[COL_W +: BANK_W];
    assign r_row  = req_addr[COL_W+BANK_W +: ROW_W];
    assign r_chip = req_addr[COL_W+BANK_W+ROW_W +: CHIP_W];
    assign r_idx  = {r_chip, r_bank};

    // Registered command pins and timing state
    sdr_cmd_e          cmd_q;
    logic [NCHIP-1:0]  cs_q;
    logic [BANK_W-1:0] ba_q;
    logic [ROW_W-1:0]  addr_q;
    logic [BYTES-1:0]  dqm_q;
    logic [GAP_W-1:0]  gap;
    logic [WR_W-1:0]   wr_rec;
    logic [BL_LOG-1:0] wcnt;
    logic [AGE_W-1:0]  act_age;

    // Decision outputs
    sdr_cmd_e          n_cmd;
    logic [NCHIP-1:0]  n_cs;
    logic [ROW_W-1:0]  n_addr;
    logic [GAP_W-1:0]  gap_val;
    logic              load_gap, accept;
    logic              set_en, clr_en, clr_all, ref_done;
    logic              look_vld, any_open, ref_pend, rd_busy;
    logic [ROW_W-1:0]  look_row;

    sps_open_rows #(.NENT(NENT), .ROW_W(ROW_W), .IDX_W(IDX_W)) rows_i (
        .clk(clk), .rst_n(rst_n), .look_idx(r_idx),
        .set_en(set_en), .set_idx(r_idx), .set_row(r_row),
        .clr_en(clr_en), .clr_idx(r_idx), .clr_all(clr_all),
        .look_vld(look_vld), .look_row(look_row), .any_open(any_open)
    );

    sps_ref_timer #(.INTERVAL(REF_INTERVAL)) ref_i (
        .clk(clk), .rst_n(rst_n), .ref_done(ref_done), .ref_pend(ref_pend)
    );

    sps_rd_track #(.BL(BL)) rdt_i (
        .clk(clk), .rst_n(rst_n), .rd_issued(cmd_q == CMD_RD),
        .cas3(cfg_cas3), .rd_beat(rd_beat), .rd_busy(rd_busy)
    );

    // Pick the next command once the previous command's gap has elapsed.
    always_comb begin
        n_cmd    = CMD_NOP;
        n_cs     = '1;
        n_addr   = '0;
        gap_val  = '0;
        load_gap = 1'b0;
        accept   = 1'b0;
        set_en   = 1'b0;
        clr_en   = 1'b0;
        clr_all  = 1'b0;
        ref_done = 1'b0;
        if (gap == '0) begin
            if (ref_pend) begin
                if (any_open) begin
                    if (wr_rec == '0) begin
                        n_cmd          = CMD_PRE;
                        n_cs           = '0;
                        n_addr[AP_BIT] = 1'b1;
                        clr_all        = 1'b1;
                        load_gap       = 1'b1;
                        gap_val        = GAP_W'(T_RP - 1);
                    end
                end else begin
                    n_cmd    = CMD_REF;
                    n_cs     = '0;
                    ref_done = 1'b1;
                    load_gap = 1'b1;
                    gap_val  = GAP_W'(T_RFC - 1);
                end
            end else if (req_valid) begin
                n_cs = ~(NCHIP'(1) << r_chip);
                if (look_vld && look_row == r_row) begin
                    n_cmd    = req_write ? CMD_WR : CMD_RD;
                    n_addr   = ROW_W'({r_col[COL_W-1:BL_LOG], {BL_LOG{1'b0}}});
                    accept   = 1'b1;
                    load_gap = 1'b1;
                    gap_val  = GAP_W'(BL - 1);
                end else if (look_vld) begin
                    if (wr_rec == '0) begin
                        n_cmd    = CMD_PRE;
                        clr_en   = 1'b1;
                        load_gap = 1'b1;
                        gap_val  = GAP_W'(T_RP - 1);
                    end else begin
                        n_cs = '1;
                    end
                end else begin
                    n_cmd    = CMD_ACT;
                    n_addr   = r_row;
                    set_en   = 1'b1;
                    load_gap = 1'b1;
                    gap_val  = GAP_W'(T_RCD - 1);
                end
            end
        end
    end

    // Register the command pins and the inter-command gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            cs_q   <= '1;
            ba_q   <= '0;
            addr_q <= '0;
            gap    <= '0;
        end else begin
            cmd_q  <= n_cmd;
            cs_q   <= n_cs;
            ba_q   <= r_bank;
            addr_q <= n_addr;
            if (load_gap)        gap <= gap_val;
            else if (gap != '0)  gap <= gap - 1'b1;
        end
    end

    // Hold write masks for the burst and count write recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqm_q  <= '0;
            wcnt   <= '0;
            wr_rec <= '0;
        end else begin
            if (accept && req_write) begin
                dqm_q  <= ~req_be;
                wcnt   <= BL_LOG'(BL - 1);
                wr_rec <= WR_W'(BL + T_WR - 2);
            end else begin
                if (wcnt != '0) wcnt <= wcnt - 1'b1;
                else            dqm_q <= '0;
                if (wr_rec != '0) wr_rec <= wr_rec - 1'b1;
            end
        end
    end

    // Age since the last ACTIVATE, saturating at T_RCD (checking aid).
    always_ff @(posedge clk) begin
        if (!rst_n)                           act_age <= AGE_W'(T_RCD);
        else if (cmd_q == CMD_ACT)            act_age <= AGE_W'(1);
        else if (act_age != AGE_W'(T_RCD))    act_age <= act_age + 1'b1;
    end

    assign req_wait = req_valid && !accept;
    assign sd_cke   = (gap != '0) || req_valid || ref_pend || (wr_rec != '0)
                      || rd_busy || (wcnt != '0);
    assign sd_cs_n  = cs_q;
    assign sd_cmd   = cmd_q;
    assign sd_ba    = ba_q;
    assign sd_addr  = addr_q;
    assign sd_dqm   = dqm_q;

    // R4
    accept_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wait) |=>
        (cmd_q == ($past(req_write) ? CMD_WR : CMD_RD)));
    // R6
    read_dqm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_RD) |-> (sd_dqm == '0));
    // R7
    act_to_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (act_age >= AGE_W'(T_RCD)));
    // R9
    ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |-> !any_open);
    // R8
    cke_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NOP) |-> sd_cke);
endmodule

// File: tb/sdram_page_sched_tb.sv
module sdram_page_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 3, T_RP = 3, T_WR = 2, T_RFC = 7, INT = 300;

    logic clk = 1'b0, rst_n = 1'b0, cfg_cas3 = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic req_wait, sd_cke, rd_beat;
    logic [1:0]  sd_cs_n, sd_ba;
    logic [2:0]  sd_cmd;
    logic [12:0] sd_addr;
    logic [3:0]  sd_dqm;

    sdram_page_sched #(.T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_RFC(T_RFC),
                       .REF_INTERVAL(INT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wait(req_wait), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_cmd(sd_cmd),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .rd_beat(rd_beat));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, cl = 2;
    // Behavioural page memory of the bench
    bit          m_vld [8];
    logic [12:0] m_row [8];
    int last_act [8], last_pre [8];
    int last_wr = -1000, last_rd = -1000, prev_rd = -1000, last_col = -1000;
    int last_ref = 0, last_ref_seen = -1000, n_refs = 0;
    logic [3:0] wr_be = '0;
    // Current request context
    int cur_idx, n_act, n_pre, n_ref, col_seen;
    logic [12:0] cur_row;
    logic [7:0]  cur_col;
    bit cur_w, cur_hit, cur_open;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic bit in_win(input int t);
        return (cyc - t) >= cl && (cyc - t) <= cl + 7;
    endfunction

    // Monitor: check every command and every data-phase output against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            int idx;
            idx = {(sd_cs_n == 2'b01) ? 1'b1 : 1'b0, sd_ba};
            if (sd_cmd != 3'd0) begin
                chk(sd_cke, "R8 cke high on command", sd_cke, 1);
                chk((cyc - last_ref_seen) >= T_RFC, "R7 refresh to next command", cyc - last_ref_seen, T_RFC);
            end
            if (sd_cmd inside {3'd1, 3'd2, 3'd3} || (sd_cmd == 3'd4 && !sd_addr[10]))
                chk(sd_cs_n == 2'b01 || sd_cs_n == 2'b10, "R1 single chip select", sd_cs_n, 1);
            case (sd_cmd)
                3'd1: begin
                    chk(!m_vld[idx], "R3 ACTIVATE only on closed bank", m_vld[idx], 0);
                    chk(idx == cur_idx && sd_addr == cur_row, "R4 ACTIVATE bank/row", sd_addr, cur_row);
                    chk((cyc - last_pre[idx]) >= T_RP, "R7 precharge to activate", cyc - last_pre[idx], T_RP);
                    m_vld[idx] = 1'b1; m_row[idx] = sd_addr; last_act[idx] = cyc; n_act++;
                end
                3'd4: begin
                    chk((cyc - (last_wr + 7)) >= T_WR, "R7 write recovery", cyc - last_wr - 7, T_WR);
                    if (sd_addr[10]) begin
                        chk(sd_cs_n == 2'b00, "R9 precharge-all selects both chips", sd_cs_n, 0);
                        for (int i = 0; i < 8; i++) begin m_vld[i] = 1'b0; last_pre[i] = cyc; end
                    end else begin
                        chk(idx == cur_idx && m_vld[idx] && m_row[idx] != cur_row,
                            "R3 precharge only the missed bank", idx, cur_idx);
                        m_vld[idx] = 1'b0; last_pre[idx] = cyc; n_pre++;
                    end
                end
                3'd5: begin
                    int open_cnt;
                    open_cnt = 0;
                    for (int i = 0; i < 8; i++) open_cnt += m_vld[i];
                    chk(open_cnt == 0 && sd_cs_n == 2'b00, "R9 refresh with all banks closed", open_cnt, 0);
                    last_ref = cyc; last_ref_seen = cyc; n_ref++; n_refs++;
                end
                3'd2, 3'd3: begin
                    chk(idx == cur_idx && m_vld[idx] && m_row[idx] == cur_row, "R4 column to open row", idx, cur_idx);
                    chk(sd_addr == {5'b0, cur_col[7:3], 3'b0}, "R4 column address", sd_addr, {cur_col[7:3], 3'b0});
                    chk((sd_cmd == 3'd3) == cur_w, "R4 command type", sd_cmd, cur_w ? 3 : 2);
                    chk((cyc - last_act[idx]) >= T_RCD, "R7 activate to column", cyc - last_act[idx], T_RCD);
                    chk((cyc - last_col) >= 8, "R5 burst spacing", cyc - last_col, 8);
                    if (n_ref == 0) begin
                        if (cur_hit)
                            chk(n_act == 0 && n_pre == 0, "R2 page hit skips activate", n_act + n_pre, 0);
                        else if (cur_open)
                            chk(n_act == 1 && n_pre == 1, "R3 miss precharge+activate", n_act * 10 + n_pre, 11);
                        else
                            chk(n_act == 1 && n_pre == 0, "R4 closed bank activate", n_act * 10 + n_pre, 10);
                    end
                    last_col = cyc; col_seen = 1;
                    if (sd_cmd == 3'd3) begin last_wr = cyc; wr_be = req_be; end
                    else begin prev_rd = last_rd; last_rd = cyc; end
                end
                default: ;
            endcase
            if ((cyc - last_wr) >= 0 && (cyc - last_wr) <= 7)
                chk(sd_dqm == ~wr_be, "R5 write byte masks", sd_dqm, ~wr_be);
            else
                chk(sd_dqm == 4'h0, "R6 masks clear outside write", sd_dqm, 0);
            chk(rd_beat == (in_win(last_rd) || in_win(prev_rd)), "R6 read beat window",
                rd_beat, in_win(last_rd) || in_win(prev_rd));
        end
    end

    task automatic do_req(input bit w, input bit chip, input logic [1:0] bank,
                          input logic [12:0] row, input logic [7:0] col, input logic [3:0] be);
        @(negedge clk); #2;
        cur_idx = {chip, bank}; cur_row = row; cur_col = col; cur_w = w;
        cur_open = m_vld[cur_idx];
        cur_hit = cur_open && m_row[cur_idx] == row;
        n_act = 0; n_pre = 0; n_ref = 0; col_seen = 0;
        req_valid = 1'b1; req_write = w; req_be = be;
        req_addr = {chip, row, bank, col};
        #1;
        if (!cur_hit) chk(req_wait, "R4 wait held on miss", req_wait, 1);
        while (req_wait) begin @(negedge clk); #2; end
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk); #3;
        chk(col_seen == 1, "R4 column after acceptance", col_seen, 1);
    endtask

    task automatic idle_cke_check(input int n);
        repeat (n) @(negedge clk);
        #2;
        if ((cyc - last_ref) < INT - 40 && (cyc - last_ref_seen) >= 12)
            chk(!sd_cke, "R8 cke low when idle", sd_cke, 0);
    endtask

    task automatic rand_req();
        logic [12:0] rows [3];
        rows[0] = 13'd5; rows[1] = 13'd9; rows[2] = 13'h1FFF;
        do_req(1'($urandom), 1'($urandom), 2'($urandom), rows[$urandom % 3],
               8'($urandom), 4'($urandom));
        if ($urandom % 4 == 0) idle_cke_check(15);
    endtask

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 8; i++) begin last_act[i] = -1000; last_pre[i] = -1000; end
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        chk(sd_cmd == 3'd0 && sd_cs_n == 2'b11, "R11 reset command NOP", sd_cmd, 0);
        chk(!sd_cke && sd_dqm == 0 && !rd_beat && !req_wait, "R11 reset outputs low",
            {sd_cke, sd_dqm, rd_beat, req_wait}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R10 same bank index on both chips stays open independently
        do_req(1'b1, 1'b0, 2'd1, 13'd5, 8'h13, 4'b0011);
        do_req(1'b1, 1'b1, 2'd1, 13'd9, 8'h40, 4'b1110);
        do_req(1'b0, 1'b0, 2'd1, 13'd5, 8'h17, 4'b0000);
        chk(n_act == 0, "R10 chip0 row kept while chip1 opened", n_act, 0);
        do_req(1'b0, 1'b1, 2'd1, 13'd9, 8'h44, 4'b0000);
        chk(n_act == 0, "R10 chip1 row kept", n_act, 0);
        // R3 miss right after a write: recovery then precharge of one bank
        do_req(1'b1, 1'b0, 2'd2, 13'd100, 8'h00, 4'b1000);
        do_req(1'b0, 1'b0, 2'd2, 13'd101, 8'h08, 4'b0000);
        chk(m_vld[5] && m_row[5] == 13'd9, "R3 other banks untouched by miss", m_row[5], 9);
        idle_cke_check(20);

        for (int i = 0; i < 120; i++) rand_req();

        // R9 long idle forces a refresh; the next access must re-activate
        begin
            int refs_before;
            refs_before = n_refs;
            do_req(1'b0, 1'b0, 2'd3, 13'd7, 8'h20, 4'b0);
            repeat (INT + 20) @(negedge clk);
            chk(n_refs > refs_before, "R9 refresh issued after interval", n_refs, refs_before + 1);
            do_req(1'b0, 1'b0, 2'd3, 13'd7, 8'h28, 4'b0);
            chk(n_act == 1, "R9 activate needed after refresh", n_act, 1);
        end

        // R6 CAS latency 3
        repeat (15) @(negedge clk);
        #2; cfg_cas3 = 1'b1; cl = 3;
        for (int i = 0; i < 80; i++) rand_req();
        do_req(1'b0, 1'b1, 2'd0, 13'd5, 8'hF9, 4'b0);
        do_req(1'b0, 1'b1, 2'd0, 13'd5, 8'h01, 4'b0);
        repeat (15) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end
endmodule